// File: doc/BRIEF.md
# Strided Vector Load Engine

This block gathers one vector into a destination vector register. It reads word-interleaved memory, starting at a base word address and stepping by a fixed stride. A single start pulse captures the base, the stride and the element count. The engine then sends at most one read per cycle to four memory banks and writes each returned word into the destination register. Results come back in issue order, so element i always lands in slot i. Memory is modelled inside the block as four bank arrays. Reset fills them with a fixed pattern, which gives the block known contents without any write path.

Each bank can take a new read only four cycles after its previous one. A stride that keeps returning to the same bank therefore holds up issue. The engine counts every cycle it spends blocked this way. With a friendly stride, reads to different banks overlap and one element is issued per cycle. The first element still pays the full read latency before the results start to stream in.

Top module: `strided_vload`

## Requirements
- R1: After synchronous reset, busy, done and stall_cnt are 0 and every destination slot reads 0. Memory word w (8-bit word address) holds the 16-bit value {w XOR 8'hC3, bitwise NOT of w}.
- R2: Slot i receives memory word (base + i*stride) mod 256, for every i below the element count.
- R3: Word w lives in bank w mod 4. A bank that accepts a read at a clock edge cannot accept another until 4 edges later, and a read aimed at a busy bank is not issued that cycle. With stride 4, n elements therefore take 3*(n-1) blocked cycles.
- R4: stall_cnt goes up by one for each cycle in which a pending read is blocked by a busy bank. It is cleared when a load is accepted.
- R5: At most one read is issued per cycle. With stride 1 the reads go to different banks on consecutive cycles and overlap, so stall_cnt stays 0.
- R6: A read issued at edge E is visible on rd_data at edge E+3. The first element therefore becomes visible 4 edges after the edge that accepts start.
- R7: Slots at or above the element count keep their previous values. A vlen above 64 is treated as 64.
- R8: done rises and busy falls at the edge that writes the last element, and done stays high until the next load is accepted. With vlen 0, done rises one edge after the accepting edge and no slot changes.
- R9: A start pulse while busy is ignored, together with its base, stride and vlen.
- R10: Stride 0 reads the base word into every slot, with 3 blocked cycles between successive reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; only accepted when idle |
| base | input | 8 | First word address |
| stride | input | 8 | Word step between elements, taken modulo 256 |
| vlen | input | 7 | Element count, 0 to 64 (larger values become 64) |
| rd_idx | input | 6 | Destination slot to read |
| rd_data | output | 16 | Contents of destination slot rd_idx |
| busy | output | 1 | A load is in progress |
| done | output | 1 | The last load has fully returned |
| stall_cnt | output | 16 | Blocked issue cycles of the current or last load |

## Verification
The bench targets strides 4 and 0, where every read falls in one bank. A design that ignored bank occupancy would report no stalls and finish too early. A design that counted the busy time wrongly would give a stall total other than 3*(n-1). Stride 2 alternates between two banks and exposes a design that charges a stall on every cycle instead of only on blocked ones. Address wrap past word 255, a short load over a longer one, a zero-length load and a start pulse during a run all test state that must stay untouched. A slipped latency stage would move the first-result and done cycles away from 4 and n+3.

// File: rtl/strided_vload_pkg.sv
package strided_vload_pkg;

    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 8;
    localparam int NBANK       = 4;
    localparam int MAX_VL      = 64;
    localparam int VL_BUSY_CYC = 4;
    localparam int VL_RD_LAT   = 3;
    localparam int STALL_W     = 16;

    localparam int BANK_W = $clog2(NBANK);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int IDX_W  = $clog2(MAX_VL);
    localparam int LEN_W  = $clog2(MAX_VL + 1);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [DATA_W-1:0] data;
    } rsp_t;

    // Power-up contents of memory word w.
    function automatic logic [DATA_W-1:0] seed_word(input logic [ADDR_W-1:0] w);
        logic [2*ADDR_W-1:0] v;
        v = {w ^ ADDR_W'('hC3), ~w};
        return DATA_W'(v);
    endfunction

endpackage

// File: rtl/strided_vload_agen.sv
module strided_vload_agen
    import strided_vload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [LEN_W-1:0]  vl,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [LEN_W-1:0]  iss_cnt,
    output logic              pending
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [LEN_W-1:0]  iss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            stride_q <= '0;
            iss_q    <= '0;
        end else if (load) begin
            addr_q   <= base;
            stride_q <= stride;
            iss_q    <= '0;
        end else if (advance) begin
            addr_q <= addr_q + stride_q;
            iss_q  <= iss_q + LEN_W'(1);
        end
    end

    assign cur_addr = addr_q;
    assign cur_idx  = iss_q[IDX_W-1:0];
    assign iss_cnt  = iss_q;
    assign pending  = iss_q < vl;
endmodule

// File: rtl/strided_vload_banks.sv
module strided_vload_banks
    import strided_vload_pkg::*;
#(
    parameter int BUSY_CYC = VL_BUSY_CYC,
    parameter int RD_LAT   = VL_RD_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              grant,
    output rsp_t              rsp
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [BANK_W-1:0] sel;
    logic [ROW_W-1:0]  row;
    logic [NBANK-1:0]  free;
    logic [DATA_W-1:0] rdata [NBANK];
    rsp_t              pipe  [RD_LAT];

    assign sel   = req_addr[BANK_W-1:0];
    assign row   = req_addr[ADDR_W-1:BANK_W];
    assign grant = req_valid && free[sel];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [CNT_W-1:0]  cnt_q;
        logic [DATA_W-1:0] mem [ROWS];

        always_ff @(posedge clk) begin
            if (rst)
                cnt_q <= '0;
            else if (grant && sel == BANK_W'(g))
                cnt_q <= CNT_W'(BUSY_CYC - 1);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int r = 0; r < ROWS; r++)
                    mem[r] <= seed_word({ROW_W'(r), BANK_W'(g)});
            end
        end

        assign free[g]  = (cnt_q == '0);
        assign rdata[g] = mem[row];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < RD_LAT; k++)
                pipe[k] <= '0;
        end else begin
            pipe[0] <= '{vld: grant, idx: req_idx, data: rdata[sel]};
            for (int k = 1; k < RD_LAT; k++)
                pipe[k] <= pipe[k-1];
        end
    end

    assign rsp = pipe[RD_LAT-1];
endmodule

// File: rtl/strided_vload_vrf.sv
module strided_vload_vrf
    import strided_vload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rsp_t              wr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slots [MAX_VL];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_VL; i++)
                slots[i] <= '0;
        end else if (wr.vld) begin
            slots[wr.idx] <= wr.data;
        end
    end

    assign rd_data = slots[rd_idx];
endmodule

// File: rtl/strided_vload.sv
module strided_vload
    import strided_vload_pkg::*;
#(
    parameter int BUSY_CYC = VL_BUSY_CYC,
    parameter int RD_LAT   = VL_RD_LAT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  stride,
    input  logic [LEN_W-1:0]   vlen,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic               busy,
    output logic               done,
    output logic [STALL_W-1:0] stall_cnt
);
    logic               busy_q, done_q;
    logic [LEN_W-1:0]   vl_q, ret_q, ret_next, vl_clamped, iss_cnt;
    logic [STALL_W-1:0] stall_q;
    logic               start_acc, req_valid, grant, pending, complete;
    logic [ADDR_W-1:0]  cur_addr;
    logic [IDX_W-1:0]   cur_idx;
    rsp_t               rsp;

    assign start_acc  = start && !busy_q;
    assign vl_clamped = (vlen > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vlen;
    assign req_valid  = busy_q && pending;
    assign ret_next   = ret_q + LEN_W'(rsp.vld);
    assign complete   = busy_q && (ret_next == vl_q);

    strided_vload_agen u_agen (
        .clk(clk), .rst(rst), .load(start_acc), .base(base), .stride(stride),
        .vl(vl_q), .advance(grant), .cur_addr(cur_addr), .cur_idx(cur_idx),
        .iss_cnt(iss_cnt), .pending(pending)
    );

    strided_vload_banks #(.BUSY_CYC(BUSY_CYC), .RD_LAT(RD_LAT)) u_banks (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(cur_addr),
        .req_idx(cur_idx), .grant(grant), .rsp(rsp)
    );

    strided_vload_vrf u_vrf (
        .clk(clk), .rst(rst), .wr(rsp), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            vl_q    <= '0;
            ret_q   <= '0;
            stall_q <= '0;
        end else if (start_acc) begin
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            vl_q    <= vl_clamped;
            ret_q   <= '0;
            stall_q <= '0;
        end else begin
            ret_q <= ret_next;
            if (complete) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
            if (req_valid && !grant)
                stall_q <= stall_q + STALL_W'(1);
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign stall_cnt = stall_q;
endmodule

// File: rtl/strided_vload_chk.sv
module strided_vload_chk
    import strided_vload_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               req_valid,
    input logic               grant,
    input logic [STALL_W-1:0] stall,
    input logic [LEN_W-1:0]   ret,
    input logic [LEN_W-1:0]   iss,
    input logic [LEN_W-1:0]   vl
);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_finish_sets_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_stall_step_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !grant) |=> (stall - $past(stall)) == STALL_W'(1));

    assert_no_stall_on_issue_R5: assert property (@(posedge clk) disable iff (rst)
        grant |=> stall == $past(stall));

    assert_return_bound_R6: assert property (@(posedge clk) disable iff (rst)
        ret <= iss);

    assert_issue_bound_R7: assert property (@(posedge clk) disable iff (rst)
        iss <= vl);
endmodule

bind strided_vload strided_vload_chk chk_i (
    .clk(clk), .rst(rst), .busy(busy_q), .done(done_q), .req_valid(req_valid),
    .grant(grant), .stall(stall_q), .ret(ret_q), .iss(iss_cnt), .vl(vl_q)
);

// File: tb/strided_vload_tb_top.sv
`timescale 1ns/1ps
module strided_vload_tb_top;
    logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [7:0]  base = '0, stride = '0;
    logic [6:0]  vlen = '0;
    logic [5:0]  rd_idx = '0;
    logic [15:0] rd_data, stall_cnt;
    logic        busy, done;

    strided_vload dut_i (
        .clk(clk), .rst(rst), .start(start), .base(base), .stride(stride),
        .vlen(vlen), .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy),
        .done(done), .stall_cnt(stall_cnt)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    bit cmp_en = 0, hold_en = 0, finished = 0;
    logic [5:0] hold_idx = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pat(input int w);
        logic [7:0] a;
        a = w[7:0];
        return int'({a ^ 8'hC3, ~a});
    endfunction

    // Behavioural reference model
    typedef struct { int idx; int data; longint due; } ent_t;
    ent_t   q[$];
    int     m_dest[64];
    longint free_at[4];
    longint cyc;
    bit     m_busy, m_done;
    int     m_vl, m_ret, m_iss, m_addr, m_stride, m_stall;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_stall = 0; m_ret = 0; m_iss = 0; m_vl = 0;
            m_addr = 0; m_stride = 0; cyc = 0;
            foreach (m_dest[i]) m_dest[i] = 0;
            foreach (free_at[i]) free_at[i] = 0;
            q.delete();
        end else begin
            bit b_old;
            int nw;
            int bk;
            b_old = m_busy;
            nw = 0;
            if (q.size() > 0 && q[0].due == cyc) begin
                m_dest[q[0].idx] = q[0].data;
                void'(q.pop_front());
                nw = 1;
            end
            if (b_old && m_iss < m_vl) begin
                bk = m_addr % 4;
                if (cyc >= free_at[bk]) begin
                    q.push_back('{m_iss, pat(m_addr), cyc + 3});
                    free_at[bk] = cyc + 4;
                    m_addr = (m_addr + m_stride) % 256;
                    m_iss++;
                end else begin
                    m_stall++;
                end
            end
            if (b_old && m_ret + nw == m_vl) begin
                m_busy = 0;
                m_done = 1;
            end
            m_ret += nw;
            if (!b_old && start) begin
                m_busy = 1; m_done = 0; m_stall = 0; m_ret = 0; m_iss = 0;
                m_addr = int'(base); m_stride = int'(stride);
                m_vl = (vlen > 64) ? 64 : int'(vlen);
            end
            cyc++;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(busy == m_busy, "R8", "busy", busy, m_busy);
            chk(done == m_done, "R8", "done", done, m_done);
            chk(stall_cnt == m_stall, "R4", "stall_cnt", stall_cnt, m_stall);
            chk(rd_data == m_dest[rd_idx], "R2", "slot data", rd_data, m_dest[rd_idx]);
            rd_idx <= hold_en ? hold_idx : rd_idx + 6'd1;
        end
    end

    task automatic peek(input int i, input int exp, input string req);
        hold_idx = i[5:0];
        hold_en = 1;
        repeat (2) @(negedge clk);
        #1;
        chk(rd_data == exp[15:0], req, "peek slot", rd_data, exp);
        hold_en = 0;
    endtask

    task automatic run_load(input int b, input int s, input int v,
                            output int n, output int first);
        int exp0;
        @(negedge clk);
        base = b[7:0]; stride = s[7:0]; vlen = v[6:0]; start = 1;
        @(negedge clk);
        start = 0;
        n = 0; first = -1; exp0 = pat(b);
        forever begin
            if (first < 0 && rd_idx == 0 && int'(rd_data) == exp0) first = n;
            if (done || n >= 2000) break;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle();
        hold_en = 0;
        repeat (70) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, first;
        repeat (3) @(negedge clk);
        chk(busy == 0, "R1", "reset busy", busy, 0);
        chk(done == 0, "R1", "reset done", done, 0);
        chk(stall_cnt == 0, "R1", "reset stall", stall_cnt, 0);
        chk(rd_data == 0, "R1", "reset slot 0", rd_data, 0);
        rst = 0;
        cmp_en = 1;

        // R5 / R6: stride 1, first result after start-up, done after vl+3
        hold_idx = 0; hold_en = 1;
        repeat (2) @(negedge clk);
        run_load(10, 1, 8, n, first);
        chk(first == 4, "R6", "first result edge", first, 4);
        chk(n == 11, "R6", "done edge", n, 11);
        chk(stall_cnt == 0, "R5", "stride1 stalls", stall_cnt, 0);
        idle();

        // R3: stride 4 hits one bank
        run_load(3, 4, 8, n, first);
        chk(stall_cnt == 21, "R3", "stride4 stalls", stall_cnt, 21);
        chk(n == 32, "R3", "stride4 done edge", n, 32);
        idle();

        // R1 / R2: whole memory pattern via a full unit-stride load
        run_load(0, 1, 64, n, first);
        chk(n == 67, "R5", "full load edge", n, 67);
        chk(stall_cnt == 0, "R5", "full load stalls", stall_cnt, 0);
        peek(63, pat(63), "R1");
        idle();

        // R10: stride 0
        run_load(77, 0, 5, n, first);
        chk(stall_cnt == 12, "R10", "stride0 stalls", stall_cnt, 12);
        for (int i = 0; i < 5; i++) peek(i, pat(77), "R10");
        idle();

        // R2: address wrap
        run_load(250, 3, 20, n, first);
        peek(2, pat(0), "R2");
        idle();

        // R3: stride 2 alternates two banks
        run_load(100, 2, 6, n, first);
        chk(stall_cnt == 4, "R3", "stride2 stalls", stall_cnt, 4);
        idle();

        // R7: short load leaves upper slots alone
        run_load(5, 1, 3, n, first);
        peek(10, pat(24), "R7");
        peek(63, pat(63), "R7");
        peek(3, pat(106), "R7");
        idle();

        // R9: start during a run is ignored
        @(negedge clk);
        base = 8'd40; stride = 8'd4; vlen = 7'd4; start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        base = 8'd200; vlen = 7'd2; start = 1;
        @(negedge clk);
        start = 0;
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        peek(1, pat(44), "R9");
        peek(3, pat(52), "R9");
        idle();

        // R8: zero-length load
        run_load(9, 1, 0, n, first);
        chk(n == 1, "R8", "vl0 done edge", n, 1);
        peek(0, pat(40), "R8");
        idle();

        // R7: oversized length clamps to 64
        run_load(128, 1, 100, n, first);
        chk(n == 67, "R7", "clamped done edge", n, 67);
        peek(63, pat(191), "R7");
        idle();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule